// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

This block paces a rolling-shutter pixel matrix one row at a time. Each row owns a fixed slot of sixteen clocks, and the rows are visited in ascending order. For every row the block drives four controls: a power window, a row select, a group select and a clamp strobe. Within each slot it also drives three strobes for the column comparators: sample, calibrate and latch. All columns are processed in parallel, so the sequencer only walks the rows.

Windows of different lengths overlap:

- A row is powered for two slots: the slot before its read and its own slot.
- A group of sixteen consecutive rows stays selected for all sixteen of its slots.
- The comparator strobes cycle once inside every slot.

After the last row the walk wraps to row 0 and a one-clock start-of-frame pulse is raised.

The sequencer runs while `en` is high. Dropping `en` blanks every control and returns the position to row 0, cycle 0. `restart` forces the walk back to row 0 while it is running. There is no data stream, so every pin is a plain level or strobe.

Top module: `row_sequencer`

## Requirements
- R1: While running, exactly one bit of `row_sel` is high, for the current row. It stays high for exactly 16 consecutive clocks, and the rows advance 0, 1, 2 … in order.
- R2: Row k (k > 0) has `row_pwr[k]` high during the slot of row k-1 and during its own slot, 32 consecutive clocks. At most two power bits are high at once, and a selected row is always powered.
- R3: `row_pwr[0]` is also high during the slot of the last row (927), so across a frame wrap it is high for 32 clocks. In the first frame after `en` rises it has no leading slot, so it is high for only 16 clocks.
- R4: `grp_sel` is one-hot with bit g = row/16, and it stays high for 256 consecutive clocks. There are 58 groups.
- R5: The slot cycle c runs from 0 to 15. `ph_rd` is high for c = 0..5, `ph_cal` for c = 6..12 and `ph_lat` for c = 13..14. In c = 15 none of them is high. At most one phase is ever high, and the order is read, then calibrate, then latch.
- R6: `clamp` is high for c = 6..8, which is three clocks inside the calibrate phase.
- R7: `sof` is high for exactly one clock, in cycle 0 of row 0. This includes the first slot after enable and every wrap from row 927 to row 0.
- R8: After reset, and in the clock after any edge that samples `en` low, all of these are 0: `row_sel`, `row_pwr`, `grp_sel`, the phases, `clamp` and `sof`. The first edge that samples `en` high starts the walk at row 0, cycle 0.
- R9: If an edge samples `restart` high while the walk is running, the next clock is row 0, cycle 0, with `sof` high. While `en` is low, `restart` has no effect and all outputs stay 0.
- R10: `row_idx` equals the current row number while running, and 0 while stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock (one slot = 16 clocks) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low blanks outputs and rewinds |
| restart | input | 1 | Frame restart request while running |
| row_sel | output | 928 | One-hot current-row select |
| row_pwr | output | 928 | Row power windows (current and next row) |
| grp_sel | output | 58 | One-hot 16-row group select |
| row_idx | output | 10 | Encoded current row |
| ph_rd | output | 1 | Comparator read phase |
| ph_cal | output | 1 | Comparator calibrate phase |
| ph_lat | output | 1 | Comparator latch phase |
| clamp | output | 1 | Clamp strobe for double sampling |
| sof | output | 1 | Start-of-frame pulse |

## Verification
Some properties are checked on every cycle:

- the one-hot shape of the row and group selects;
- the bound of two powered rows, and that the selected row is powered;
- phase exclusivity, the read-calibrate-latch order, and clamp lying inside calibrate;
- the blanking that follows a low enable, and the start-of-frame that follows a restart.

The window lengths (16, 32 and 256 clocks), the short first-frame power window of row 0, and the 32-clock window of row 0 across the frame wrap need whole scenarios. So does the exact slot position of every strobe across two full frames, a mid-frame restart and a stop and resume. Only the bench's cycle-accurate reference model shows these.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_CAL  = 2'd2,
    PH_LAT  = 2'd3
  } phase_e;
endpackage

// File: rtl/rowseq_slot_timer.sv
module rowseq_slot_timer
  import rowseq_pkg::*;
#(
  parameter int SLOT_CLKS = 16,
  parameter int RD_LEN    = 6,
  parameter int CAL_LEN   = 7,
  parameter int LAT_LEN   = 2,
  parameter int CLAMP_LEN = 3,
  localparam int CYC_W    = $clog2(SLOT_CLKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             act,
  input  logic             restart,
  output logic [CYC_W-1:0] cyc,
  output logic             slot_end,
  output phase_e           phase,
  output logic             clamp
);
  // phase boundaries; RD_LEN+CAL_LEN+LAT_LEN must stay below SLOT_CLKS
  localparam logic [CYC_W-1:0] CAL_FIRST  = CYC_W'(RD_LEN);
  localparam logic [CYC_W-1:0] LAT_FIRST  = CYC_W'(RD_LEN + CAL_LEN);
  localparam logic [CYC_W-1:0] IDLE_FIRST = CYC_W'(RD_LEN + CAL_LEN + LAT_LEN);
  localparam logic [CYC_W-1:0] CLAMP_END  = CYC_W'(RD_LEN + CLAMP_LEN);
  localparam logic [CYC_W-1:0] CYC_LAST   = CYC_W'(SLOT_CLKS - 1);

  assign slot_end = act && (cyc == CYC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || (act && restart)) cyc <= '0;
    else if (act)                        cyc <= slot_end ? '0 : cyc + 1'b1;
  end

  always_comb begin
    phase = PH_IDLE;
    if (act) begin
      if      (cyc < CAL_FIRST)  phase = PH_RD;
      else if (cyc < LAT_FIRST)  phase = PH_CAL;
      else if (cyc < IDLE_FIRST) phase = PH_LAT;
    end
  end

  assign clamp = act && (cyc >= CAL_FIRST) && (cyc < CLAMP_END);
endmodule

// File: rtl/rowseq_row_counter.sv
module rowseq_row_counter #(
  parameter int N_ROWS   = 928,
  parameter int GRP_ROWS = 16,
  localparam int N_GRPS  = N_ROWS / GRP_ROWS,
  localparam int ROW_W   = $clog2(N_ROWS),
  localparam int GRP_W   = $clog2(N_GRPS),
  localparam int SUB_W   = $clog2(GRP_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             act,
  input  logic             restart,
  input  logic             slot_end,
  output logic [ROW_W-1:0] row,
  output logic [GRP_W-1:0] grp
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(N_ROWS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(GRP_ROWS - 1);

  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst || !en || (act && restart)) begin
      row <= '0;
      sub <= '0;
      grp <= '0;
    end else if (slot_end) begin
      if (row == ROW_LAST) begin
        row <= '0;
        sub <= '0;
        grp <= '0;
      end else begin
        row <= row + 1'b1;
        if (sub == SUB_LAST) begin
          sub <= '0;
          grp <= grp + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rowseq_decoder.sv
module rowseq_decoder #(
  parameter int N_ROWS   = 928,
  parameter int GRP_ROWS = 16,
  localparam int N_GRPS  = N_ROWS / GRP_ROWS,
  localparam int ROW_W   = $clog2(N_ROWS),
  localparam int GRP_W   = $clog2(N_GRPS)
) (
  input  logic              act,
  input  logic [ROW_W-1:0]  row,
  input  logic [GRP_W-1:0]  grp,
  output logic [N_ROWS-1:0] row_sel,
  output logic [N_ROWS-1:0] row_pwr,
  output logic [N_GRPS-1:0] grp_sel
);
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    localparam int PREV = (r == 0) ? N_ROWS - 1 : r - 1;
    assign row_sel[r] = act && (row == ROW_W'(r));
    // powered in the slot ahead of its own read, then through it
    assign row_pwr[r] = act && ((row == ROW_W'(r)) || (row == ROW_W'(PREV)));
  end

  for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
    assign grp_sel[g] = act && (grp == GRP_W'(g));
  end
endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
  import rowseq_pkg::*;
#(
  parameter int N_ROWS    = 928,
  parameter int GRP_ROWS  = 16,
  parameter int SLOT_CLKS = 16,
  parameter int RD_LEN    = 6,
  parameter int CAL_LEN   = 7,
  parameter int LAT_LEN   = 2,
  parameter int CLAMP_LEN = 3,
  localparam int N_GRPS   = N_ROWS / GRP_ROWS,
  localparam int ROW_W    = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              restart,
  output logic [N_ROWS-1:0] row_sel,
  output logic [N_ROWS-1:0] row_pwr,
  output logic [N_GRPS-1:0] grp_sel,
  output logic [ROW_W-1:0]  row_idx,
  output logic              ph_rd,
  output logic              ph_cal,
  output logic              ph_lat,
  output logic              clamp,
  output logic              sof
);
  localparam int CYC_W = $clog2(SLOT_CLKS);
  localparam int GRP_W = $clog2(N_GRPS);

  logic             act;
  logic [CYC_W-1:0] cyc;
  logic             slot_end;
  phase_e           phase;
  logic [GRP_W-1:0] grp;

  always_ff @(posedge clk) begin
    if (rst) act <= 1'b0;
    else     act <= en;
  end

  rowseq_slot_timer #(
    .SLOT_CLKS(SLOT_CLKS), .RD_LEN(RD_LEN), .CAL_LEN(CAL_LEN),
    .LAT_LEN(LAT_LEN), .CLAMP_LEN(CLAMP_LEN)
  ) u_slot (
    .clk(clk), .rst(rst), .en(en), .act(act), .restart(restart),
    .cyc(cyc), .slot_end(slot_end), .phase(phase), .clamp(clamp)
  );

  rowseq_row_counter #(.N_ROWS(N_ROWS), .GRP_ROWS(GRP_ROWS)) u_rows (
    .clk(clk), .rst(rst), .en(en), .act(act), .restart(restart),
    .slot_end(slot_end), .row(row_idx), .grp(grp)
  );

  rowseq_decoder #(.N_ROWS(N_ROWS), .GRP_ROWS(GRP_ROWS)) u_dec (
    .act(act), .row(row_idx), .grp(grp),
    .row_sel(row_sel), .row_pwr(row_pwr), .grp_sel(grp_sel)
  );

  assign ph_rd  = (phase == PH_RD);
  assign ph_cal = (phase == PH_CAL);
  assign ph_lat = (phase == PH_LAT);
  assign sof    = act && (row_idx == '0) && (cyc == '0);
endmodule

// File: rtl/rowseq_chk.sv
module rowseq_chk #(
  parameter int N_ROWS = 928,
  parameter int N_GRPS = 58,
  parameter int ROW_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              restart,
  input logic [N_ROWS-1:0] row_sel,
  input logic [N_ROWS-1:0] row_pwr,
  input logic [N_GRPS-1:0] grp_sel,
  input logic [ROW_W-1:0]  row_idx,
  input logic              ph_rd,
  input logic              ph_cal,
  input logic              ph_lat,
  input logic              clamp,
  input logic              sof
);
  // R1
  rsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  // R1
  rsel_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (row_sel != '0) |-> row_sel[row_idx]);
  // R2
  pwr_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(row_pwr) <= 2);
  // R2
  sel_powered_chk: assert property (@(posedge clk) disable iff (rst)
    (row_sel & ~row_pwr) == '0);
  // R4
  grp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_sel) && ((row_sel != '0) == (grp_sel != '0)));
  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ph_rd, ph_cal, ph_lat}));
  // R5
  cal_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_cal) |-> $past(ph_rd));
  // R5
  lat_after_cal_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ph_lat) |-> $past(ph_cal));
  // R6
  clamp_in_cal_chk: assert property (@(posedge clk) disable iff (rst)
    clamp |-> ph_cal);
  // R7
  sof_pos_chk: assert property (@(posedge clk) disable iff (rst)
    sof |-> (row_sel[0] && ph_rd && row_idx == '0));
  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (row_sel == '0 && row_pwr == '0 && grp_sel == '0 &&
             !ph_rd && !ph_cal && !ph_lat && !clamp && !sof));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && en && row_sel != '0) |=> sof);
endmodule

bind row_sequencer rowseq_chk #(.N_ROWS(N_ROWS), .N_GRPS(N_GRPS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .restart(restart),
  .row_sel(row_sel), .row_pwr(row_pwr), .grp_sel(grp_sel), .row_idx(row_idx),
  .ph_rd(ph_rd), .ph_cal(ph_cal), .ph_lat(ph_lat), .clamp(clamp), .sof(sof)
);

// File: tb/row_sequencer_tb.sv
module row_sequencer_tb;
  localparam int NR = 928;
  localparam int NG = 58;
  localparam int FRAME = NR * 16;

  typedef struct packed {
    logic        act;
    logic [9:0]  row;
    logic [3:0]  cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic restart = 1'b0;
  logic [NR-1:0] row_sel, row_pwr;
  logic [NG-1:0] grp_sel;
  logic [9:0] row_idx;
  logic ph_rd, ph_cal, ph_lat, clamp, sof;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  exp_t q[$];

  bit m_act = 1'b0;
  int m_row = 0;
  int m_cyc = 0;

  int run_sel5 = 0, run_pwr5 = 0, run_grp1 = 0, run_pwr0 = 0;
  int len_sel5 = -1, len_pwr5 = -1, len_grp1 = -1;
  int len_pwr0_a = -1, len_pwr0_b = -1;

  always #10 clk = ~clk;

  row_sequencer u_dut (
    .clk(clk), .rst(rst), .en(en), .restart(restart),
    .row_sel(row_sel), .row_pwr(row_pwr), .grp_sel(grp_sel), .row_idx(row_idx),
    .ph_rd(ph_rd), .ph_cal(ph_cal), .ph_lat(ph_lat), .clamp(clamp), .sof(sof)
  );

  function automatic void chk(bit ok, string req, string act_s, string exp_s);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act_s, exp_s);
    end
  endfunction

  // driver: sets inputs for the next edge and pushes the expected state
  task automatic step(input bit e, input bit r);
    @(negedge clk);
    en = e;
    restart = r;
    if (!e) begin
      m_act = 1'b0; m_row = 0; m_cyc = 0;
    end else if (!m_act) begin
      m_act = 1'b1;
    end else if (r) begin
      m_row = 0; m_cyc = 0;
    end else if (m_cyc == 15) begin
      m_cyc = 0;
      m_row = (m_row == NR - 1) ? 0 : m_row + 1;
    end else begin
      m_cyc++;
    end
    q.push_back('{m_act, 10'(m_row), 4'(m_cyc)});
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t x;
        logic [NR-1:0] one, e_sel, e_pwr;
        logic [NG-1:0] g1, e_grp;
        logic e_rd, e_cal, e_lat, e_clamp, e_sof;
        int c;
        x = q.pop_front();
        c = int'(x.cyc);
        one = '0; one[0] = 1'b1;
        g1 = '0; g1[0] = 1'b1;
        e_sel = x.act ? (one << x.row) : '0;                          // R1
        e_pwr = x.act ? ((one << x.row) |
                         (one << ((int'(x.row) + 1) % NR))) : '0;     // R2 R3
        e_grp = x.act ? (g1 << (int'(x.row) / 16)) : '0;              // R4
        e_rd  = x.act && c <= 5;                                      // R5
        e_cal = x.act && c >= 6 && c <= 12;
        e_lat = x.act && c >= 13 && c <= 14;
        e_clamp = x.act && c >= 6 && c <= 8;                          // R6
        e_sof = x.act && x.row == 0 && c == 0;                        // R7
        chk(row_sel === e_sel, "R1 row_sel", $sformatf("%0d", $clog2(row_sel + 1)),
            $sformatf("row %0d act %0b", x.row, x.act));
        chk(row_pwr === e_pwr, "R2 row_pwr", $sformatf("ones=%0d", $countones(row_pwr)),
            $sformatf("row %0d act %0b", x.row, x.act));
        chk(grp_sel === e_grp, "R4 grp_sel", $sformatf("%h", grp_sel), $sformatf("%h", e_grp));
        chk({ph_rd, ph_cal, ph_lat} === {e_rd, e_cal, e_lat}, "R5 phases",
            $sformatf("%b", {ph_rd, ph_cal, ph_lat}), $sformatf("%b", {e_rd, e_cal, e_lat}));
        chk(clamp === e_clamp, "R6 clamp", $sformatf("%b", clamp), $sformatf("%b", e_clamp));
        chk(sof === e_sof, "R7 sof", $sformatf("%b", sof), $sformatf("%b", e_sof));
        chk(row_idx === x.row, "R10 row_idx", $sformatf("%0d", row_idx), $sformatf("%0d", x.row));
        // window length measurement
        if (row_sel[5]) run_sel5++; else if (run_sel5 > 0) begin
          if (len_sel5 < 0) len_sel5 = run_sel5; run_sel5 = 0; end
        if (row_pwr[5]) run_pwr5++; else if (run_pwr5 > 0) begin
          if (len_pwr5 < 0) len_pwr5 = run_pwr5; run_pwr5 = 0; end
        if (grp_sel[1]) run_grp1++; else if (run_grp1 > 0) begin
          if (len_grp1 < 0) len_grp1 = run_grp1; run_grp1 = 0; end
        if (row_pwr[0]) run_pwr0++; else if (run_pwr0 > 0) begin
          if (len_pwr0_a < 0) len_pwr0_a = run_pwr0;
          else if (len_pwr0_b < 0) len_pwr0_b = run_pwr0;
          run_pwr0 = 0;
        end
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(row_sel == '0 && row_pwr == '0 && grp_sel == '0, "R8 reset vectors",
        "nonzero", "zero");
    chk({ph_rd, ph_cal, ph_lat, clamp, sof} == 5'b0 && row_idx == '0, "R8 reset strobes",
        $sformatf("%b", {ph_rd, ph_cal, ph_lat, clamp, sof}), "00000");
    @(negedge clk);
    rst = 1'b0;
    // R9 restart ignored while stopped
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    // two full frames from enable: wraps, sof, window lengths (R1..R7)
    for (int i = 0; i < 2 * FRAME + 40; i++) step(1'b1, 1'b0);
    // R9 mid-frame restart
    for (int i = 0; i < 123; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0);
    // R8 stop and resume
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(len_sel5 == 16, "R1 select window", $sformatf("%0d", len_sel5), "16");
    chk(len_pwr5 == 32, "R2 power window", $sformatf("%0d", len_pwr5), "32");
    chk(len_grp1 == 256, "R4 group window", $sformatf("%0d", len_grp1), "256");
    chk(len_pwr0_a == 16, "R3 first-frame row0 power", $sformatf("%0d", len_pwr0_a), "16");
    chk(len_pwr0_b == 32, "R3 wrapped row0 power", $sformatf("%0d", len_pwr0_b), "32");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule